// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the register-programming side of an eight-input, 8259-style interrupt controller. Software reaches it through byte writes on a two-address port, chosen by a single address-select bit. A write to the even address with bit 4 set starts an initialization sequence. The odd-address writes that follow are routed by a small state machine to the vector base, the cascade setup and the mode word. Once the sequence ends, odd-address writes load the interrupt mask.

Starting a sequence also resets several things as a side effect. The mask is cleared, input 7 becomes the lowest-priority input, the slave address returns to 7 and special mask mode is switched off. Even-address writes with bit 4 clear are operation commands. Two of them are decoded here: the one that sets the lowest-priority input, and the one that sets or clears special mask mode. A parameter selects whether the instance is a master or a slave, which decides how the cascade word is stored. All stored state is presented on output ports to the arbitration logic, which lies outside this block.

Top module: `pic_init_seq`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows. `vector_base`, `irq_mask`, `slave_mask`, `single_mode`, `icw4_req`, `addr_int4`, `cpu_mode`, `special_mask`, `seq_busy` and `init_done` are all 0. `lowest_prio` and `slave_id` are both 7.
- R2: A write with `addr_sel`=0 and `wdata[4]`=1 starts a sequence, in any state. It latches three fields: `wdata[0]` into `icw4_req`, `wdata[1]` into `single_mode` and `wdata[2]` into `addr_int4`. It also clears `cpu_mode` and `init_done` and sets `seq_busy`.
- R3: The same sequence-start write sets `irq_mask` to 0x00, `lowest_prio` to 7, `slave_id` to 7 and `special_mask` to 0.
- R4: The first `addr_sel`=1 write after a sequence start loads all 8 bits of `wdata` into `vector_base`.
- R5: The cascade word is the next odd write. On a master (`IS_SLAVE`=0) it loads all 8 bits into `slave_mask` and leaves `slave_id` unchanged. On a slave it loads `wdata[2:0]` into `slave_id`, and `slave_mask` stays 0.
- R6: The mode word, when it is expected, loads `wdata[0]` into `cpu_mode`.
- R7: The cascade word is skipped when `single_mode` is 1, and the mode word is skipped when `icw4_req` is 0. The write that is the last expected word clears `seq_busy` and sets `init_done` in the following cycle.
- R8: When `seq_busy` is 0, an odd write loads `wdata` into `irq_mask`, where a 1 masks an input. Odd writes never change `irq_mask` while `seq_busy` is 1.
- R9: A sequence-start write that arrives in the middle of a sequence restarts it. The next odd write goes to `vector_base`.
- R10: With `seq_busy`=0, consider an even write with `wdata[4]`=0 and `wdata[3]`=0. If `wdata[7:6]`=2'b11, it sets `lowest_prio` to `wdata[2:0]`. Other values of `wdata[7:6]` leave all outputs unchanged.
- R11: With `seq_busy`=0, consider an even write with `wdata[4]`=0 and `wdata[3]`=1. If `wdata[6]`=1, it sets `special_mask` to `wdata[5]`. If `wdata[6]`=0, all outputs stay unchanged.
- R12: Even writes with `wdata[4]`=0 are ignored while `seq_busy` is 1. No output changes while `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr_sel | input | 1 | 0 = even (command) address, 1 = odd (data) address |
| wdata | input | 8 | Write data |
| vector_base | output | 8 | Interrupt vector base |
| single_mode | output | 1 | No cascading |
| icw4_req | output | 1 | Mode word expected in sequence |
| addr_int4 | output | 1 | Call address interval bit |
| cpu_mode | output | 1 | Microprocessor mode |
| slave_mask | output | 8 | Inputs with a slave attached (master only) |
| slave_id | output | 3 | Slave address |
| irq_mask | output | 8 | Interrupt mask, 1 = masked |
| lowest_prio | output | 3 | Input holding lowest priority |
| special_mask | output | 1 | Special mask mode |
| seq_busy | output | 1 | Initialization sequence in progress |
| init_done | output | 1 | Sequence completed |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. They check the side effects of a sequence start and the hold on the mask during a sequence. They also check that the vector base is frozen outside a sequence, that the cascade step never occurs in single mode, and that completion and busy never overlap. Other behaviour depends on where a write falls in the sequence, and only the bench's scenarios can show it. That covers word routing with and without the cascade and mode words, restarts in the middle of a sequence, and the ignored operation commands. The bench shows these by comparing a behavioural reference model with every output on every clock, and it programs a slave instance as well.

// File: rtl/pic_init_seq.sv
module pic_init_seq #(
  parameter bit IS_SLAVE = 1'b0,
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] vector_base,
  output logic          single_mode,
  output logic          icw4_req,
  output logic          addr_int4,
  output logic          cpu_mode,
  output logic [DW-1:0] slave_mask,
  output logic [LW-1:0] slave_id,
  output logic [DW-1:0] irq_mask,
  output logic [LW-1:0] lowest_prio,
  output logic          special_mask,
  output logic          seq_busy,
  output logic          init_done
);

  typedef enum logic [1:0] {S_RDY, S_VEC, S_CAS, S_MOD} st_t;
  st_t st;

  localparam logic [LW-1:0] TOP_IN = LW'(DW - 1);

  wire start  = wr_en & ~addr_sel & wdata[4];
  wire cmd_ok = wr_en & ~addr_sel & ~wdata[4] & (st == S_RDY);
  wire prio_w = cmd_ok & ~wdata[3] & (wdata[7:6] == 2'b11);
  wire smm_w  = cmd_ok & wdata[3] & wdata[6];
  wire odd_w  = wr_en & addr_sel;

  assign seq_busy = (st != S_RDY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_RDY;
      vector_base  <= '0;
      single_mode  <= 1'b0;
      icw4_req     <= 1'b0;
      addr_int4    <= 1'b0;
      cpu_mode     <= 1'b0;
      slave_mask   <= '0;
      slave_id     <= TOP_IN;
      irq_mask     <= '0;
      lowest_prio  <= TOP_IN;
      special_mask <= 1'b0;
      init_done    <= 1'b0;
    end else if (start) begin
      st           <= S_VEC;
      icw4_req     <= wdata[0];
      single_mode  <= wdata[1];
      addr_int4    <= wdata[2];
      cpu_mode     <= 1'b0;
      init_done    <= 1'b0;
      irq_mask     <= '0;
      lowest_prio  <= TOP_IN;
      slave_id     <= TOP_IN;
      special_mask <= 1'b0;
    end else if (odd_w) begin
      unique case (st)
        S_RDY: irq_mask <= wdata;
        S_VEC: begin
          vector_base <= wdata;
          if (!single_mode)  st <= S_CAS;
          else if (icw4_req) st <= S_MOD;
          else begin st <= S_RDY; init_done <= 1'b1; end
        end
        S_CAS: begin
          if (IS_SLAVE) slave_id <= wdata[LW-1:0];
          else          slave_mask <= wdata;
          if (icw4_req) st <= S_MOD;
          else begin st <= S_RDY; init_done <= 1'b1; end
        end
        S_MOD: begin
          cpu_mode  <= wdata[0];
          st        <= S_RDY;
          init_done <= 1'b1;
        end
      endcase
    end else if (prio_w) begin
      lowest_prio <= wdata[LW-1:0];
    end else if (smm_w) begin
      special_mask <= wdata[5];
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (irq_mask == '0) && (lowest_prio == TOP_IN) && !special_mask && seq_busy); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> seq_busy && !init_done && !cpu_mode); // R2
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !start) |=> $stable(irq_mask)); // R8
  AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !start) |=> $stable(vector_base)); // R4
  AST_NO_CAS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAS) |-> !single_mode); // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_busy && init_done)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_mask) && $stable(lowest_prio) && $stable(special_mask)); // R12

endmodule

// File: tb/test_pic_init_seq.sv
module test_pic_init_seq;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] vector_base, slave_mask, irq_mask;
  logic [2:0] slave_id, lowest_prio;
  logic single_mode, icw4_req, addr_int4, cpu_mode, special_mask, seq_busy, init_done;

  logic swr = 1'b0, srst_n = 1'b0, sa = 1'b0;
  logic [7:0] sd = 8'h00;
  logic [7:0] s_vec, s_smask, s_mask;
  logic [2:0] s_id, s_prio;
  logic s_sng, s_ic4, s_adi, s_cpu, s_smm, s_busy, s_done;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pic_init_seq i_pic_init_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_sel(addr_sel), .wdata(wdata),
    .vector_base(vector_base), .single_mode(single_mode), .icw4_req(icw4_req),
    .addr_int4(addr_int4), .cpu_mode(cpu_mode), .slave_mask(slave_mask),
    .slave_id(slave_id), .irq_mask(irq_mask), .lowest_prio(lowest_prio),
    .special_mask(special_mask), .seq_busy(seq_busy), .init_done(init_done));

  pic_init_seq #(.IS_SLAVE(1'b1)) i_pic_init_seq_slv (
    .clk(clk), .rst_n(srst_n), .wr_en(swr), .addr_sel(sa), .wdata(sd),
    .vector_base(s_vec), .single_mode(s_sng), .icw4_req(s_ic4),
    .addr_int4(s_adi), .cpu_mode(s_cpu), .slave_mask(s_smask),
    .slave_id(s_id), .irq_mask(s_mask), .lowest_prio(s_prio),
    .special_mask(s_smm), .seq_busy(s_busy), .init_done(s_done));

  // behavioural reference of the master: remaining words kept in a queue
  string pend[$];
  int m_vec, m_smask, m_id, m_mask, m_prio;
  bit m_sng, m_ic4, m_adi, m_cpu, m_smm, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = {}; m_vec = 0; m_smask = 0; m_id = 7; m_mask = 0; m_prio = 7;
      m_sng = 0; m_ic4 = 0; m_adi = 0; m_cpu = 0; m_smm = 0; m_done = 0;
    end else if (wr_en) begin
      if (!addr_sel && wdata[4]) begin
        m_ic4 = wdata[0]; m_sng = wdata[1]; m_adi = wdata[2];
        m_cpu = 0; m_done = 0; m_mask = 0; m_prio = 7; m_id = 7; m_smm = 0;
        pend = {"vec"};
        if (!wdata[1]) pend.push_back("cas");
        if (wdata[0])  pend.push_back("mod");
      end else if (addr_sel) begin
        if (pend.size() == 0) m_mask = wdata;
        else begin
          string w;
          w = pend.pop_front();
          if (w == "vec") m_vec = wdata;
          else if (w == "cas") m_smask = wdata;
          else m_cpu = wdata[0];
          if (pend.size() == 0) m_done = 1;
        end
      end else if (pend.size() == 0) begin
        if (!wdata[3] && wdata[7:6] == 2'b11) m_prio = wdata[2:0];
        else if (wdata[3] && wdata[6]) m_smm = wdata[5];
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R4", "vector_base", vector_base, m_vec);
    chk("R2", "mode bits", {single_mode, icw4_req, addr_int4}, {m_sng, m_ic4, m_adi});
    chk("R6", "cpu_mode", cpu_mode, m_cpu);
    chk("R5", "slave_mask", slave_mask, m_smask);
    chk("R3", "slave_id", slave_id, m_id);
    chk("R8", "irq_mask", irq_mask, m_mask);
    chk("R10", "lowest_prio", lowest_prio, m_prio);
    chk("R11", "special_mask", special_mask, m_smm);
    chk("R7", "busy/done", {seq_busy, init_done}, {pend.size() != 0, m_done});
  end

  task automatic put(bit a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr_sel = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = ~d;
  endtask

  task automatic sput(bit a, logic [7:0] d);
    @(negedge clk); swr = 1'b1; sa = a; sd = d;
    @(negedge clk); swr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset outputs", {vector_base, irq_mask, slave_mask, seq_busy, init_done, cpu_mode, special_mask},
        {8'h00, 8'h00, 8'h00, 5'b0});
    chk("R1", "reset prio/id", {lowest_prio, slave_id}, {3'd7, 3'd7});
    rst_n = 1'b1; srst_n = 1'b1;
    // R2 R4 R5 R6 full cascaded sequence on master
    put(0, 8'h11); put(1, 8'h20); put(1, 8'h04); put(1, 8'h01);
    chk("R5", "master cascade mask", slave_mask, 8'h04);
    chk("R6", "cpu mode set", cpu_mode, 1);
    chk("R7", "done after mode word", init_done, 1);
    // R8 mask
    put(1, 8'hFB);
    chk("R8", "mask load", irq_mask, 8'hFB);
    // R10 R11 operation commands
    put(0, 8'hC3); chk("R10", "priority set", lowest_prio, 3);
    put(0, 8'h20); chk("R10", "other cmd ignored", lowest_prio, 3);
    put(0, 8'h68); chk("R11", "smm on", special_mask, 1);
    put(0, 8'h28); chk("R11", "smm unchanged", special_mask, 1);
    // R12 idle input noise
    repeat (4) begin @(negedge clk); addr_sel = ~addr_sel; wdata = wdata + 8'h35; end
    chk("R12", "idle mask held", irq_mask, 8'hFB);
    // R3 R7 single mode without mode word
    put(0, 8'h12);
    chk("R3", "mask cleared", irq_mask, 0);
    chk("R3", "prio reset", lowest_prio, 7);
    put(1, 8'h40);
    chk("R7", "done after vector only", init_done, 1);
    // R7 single mode with mode word
    put(0, 8'h13); put(1, 8'h48);
    chk("R7", "still busy", seq_busy, 1);
    put(1, 8'h01);
    chk("R7", "cascade untouched", slave_mask, 8'h04);
    // R9 restart mid-sequence
    put(0, 8'h11); put(1, 8'h30); put(0, 8'h15); put(1, 8'h50);
    chk("R9", "restart vector", vector_base, 8'h50);
    put(1, 8'h80); put(1, 8'h00);
    chk("R9", "restart cascade", slave_mask, 8'h80);
    // R12 command during sequence ignored
    put(0, 8'h11); put(0, 8'hC5);
    chk("R12", "cmd ignored while busy", lowest_prio, 7);
    put(1, 8'h08); put(1, 8'h04); put(1, 8'h01);
    put(1, 8'hA5); chk("R8", "mask after init", irq_mask, 8'hA5);
    // R5 slave instance
    sput(0, 8'h11); sput(1, 8'h28); sput(1, 8'h02); sput(1, 8'h01);
    chk("R5", "slave id", s_id, 2);
    chk("R5", "slave mask zero", s_smask, 0);
    chk("R4", "slave vector", s_vec, 8'h28);
    chk("R7", "slave done", s_done, 1);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule